// File: doc/BRIEF.md
# Slewing Time-of-Day Counter

This block keeps wall-clock time for precision time stamping. It holds a 48-bit seconds count, a 30-bit nanoseconds count and a 16-bit fractional-nanosecond accumulator. On every clock edge the time advances by a programmable fixed-point increment. Software reaches the counter through a single-cycle 32-bit register port. Through this port it loads the time, reads a coherent snapshot of it and steers it.

Three correction mechanisms act on the increment:
- The nominal period sets the rate and serves as a frequency trim.
- A temporary period can replace the nominal one for a programmed number of cycles. This slews the time offset without a jump.
- A small fractional drift term can be added once every N cycles.

The live time is also driven on output ports for local consumers.

Top module: `tod_clock`

## Requirements
- R1: After reset the seconds, nanoseconds and fraction are zero, and every register reads zero: nominal period, slew period, slew count, drift amount and drift interval. With a zero period the time stays at zero.
- R2: On each clock edge the time advances by the active increment. The increment is a 20-bit unsigned value with 4 integer and 16 fractional nanosecond bits, so 0x18000 means 1.5 ns. Fractions accumulate across cycles.
- R3: When nanoseconds reach 1,000,000,000 or more they wrap by subtracting that value, and the 48-bit seconds count gains one. The carry runs across all 48 bits.
- R4: Writes to seconds-high (word 0, byte 0x00, bits 15:0 used) and seconds-low (word 1, byte 0x04) are only staged and leave the running time untouched. A write to nanoseconds (word 2, byte 0x08, bits 29:0, value below 10^9) loads the staged seconds and the written nanoseconds in one edge and clears the fraction.
- R5: Read data appears on the register port one cycle after the read strobe. A nanoseconds read returns the current nanoseconds and captures the seconds at that same edge. Later reads of seconds-low and seconds-high return that capture. Seconds-high returns the upper 16 seconds bits with bits 31:16 zero.
- R6: Writing a count N to the slew count register (word 6, byte 0x18, 20 bits) makes the slew period (word 5, byte 0x14, 20 bits) replace the nominal period (word 4, byte 0x10) on each of the N edges after the write. The count drops by one per edge and reads zero once the slew is done.
- R7: The drift amount (word 7, byte 0x1C, 16 bits, units of 2^-16 ns) is added once every R edges, where R is the drift interval (word 8, byte 0x20, 16 bits). R = 0 disables the correction. Writing the interval restarts its cycle count, so the first addition lands on the R-th edge after the write.
- R8: Register writes keep only the field width: 20 bits for both periods and the count, 16 for drift amount and interval. Word 3 (byte 0x0C) reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_word | input | 4 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| time_sec | output | 48 | Live seconds count |
| time_ns | output | 30 | Live nanoseconds count |

## Verification
The assertions rely on software keeping its inputs legal:
- Any nanoseconds value it loads must be below 10^9.
- Read and write strobes must not both be high for the slew count register in the same cycle.

With these held, the nanoseconds range check and the one-second-per-step check can hold in every cycle. The directed tasks only load nanoseconds values below 10^9 and issue each bus access alone. Tests that need a static time set the period to zero, so exact values can be predicted edge by edge.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam longint unsigned NS_PER_SEC = 64'd1_000_000_000;

  typedef enum logic [3:0] {
    W_SEC_HI = 4'd0,
    W_SEC_LO = 4'd1,
    W_NS     = 4'd2,
    W_RSVD   = 4'd3,
    W_PER    = 4'd4,
    W_APER   = 4'd5,
    W_ACNT   = 4'd6,
    W_DAMT   = 4'd7,
    W_DRATE  = 4'd8
  } word_e;
endpackage

// File: rtl/tod_time.sv
module tod_time #(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int FRAC_W = 16,
  parameter int INC_W  = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [SEC_W-1:0]  load_sec,
  input  logic [NS_W-1:0]   load_ns,
  input  logic [INC_W-1:0]  inc,
  output logic [SEC_W-1:0]  sec_o,
  output logic [NS_W-1:0]   ns_o
);
  localparam int ACC_W = NS_W + FRAC_W;
  localparam logic [ACC_W:0] WRAP = (ACC_W+1)'(tod_pkg::NS_PER_SEC) << FRAC_W;

  logic [ACC_W-1:0] acc;
  logic [SEC_W-1:0] sec;
  logic [ACC_W:0]   sum;
  logic             roll;

  assign sum  = {1'b0, acc} + (ACC_W+1)'(inc);
  assign roll = (sum >= WRAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      sec <= '0;
    end else if (load) begin
      acc <= {load_ns, {FRAC_W{1'b0}}};
      sec <= load_sec;
    end else if (roll) begin
      acc <= ACC_W'(sum - WRAP);
      sec <= sec + 1'b1;
    end else begin
      acc <= sum[ACC_W-1:0];
    end
  end

  assign sec_o = sec;
  assign ns_o  = acc[ACC_W-1:FRAC_W];

  // R3
  ns_range_chk: assert property (@(posedge clk) disable iff (rst)
    {1'b0, acc} < WRAP);

  // R3
  sec_step_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> (sec == $past(sec)) || (sec == $past(sec) + 1'b1));
endmodule

// File: rtl/tod_slew.sv
module tod_slew #(
  parameter int PER_W   = 20,
  parameter int CNT_W   = 20,
  parameter int DRIFT_W = 16,
  parameter int RATE_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PER_W-1:0]   period,
  input  logic [PER_W-1:0]   adj_period,
  input  logic [DRIFT_W-1:0] drift_amt,
  input  logic [RATE_W-1:0]  drift_rate,
  input  logic               cnt_wr,
  input  logic [CNT_W-1:0]   cnt_val,
  input  logic               rate_wr,
  output logic [PER_W:0]     inc,
  output logic [CNT_W-1:0]   adj_cnt
);
  logic [RATE_W-1:0] dcnt;
  logic              slewing;
  logic              fire;
  logic [PER_W-1:0]  base;

  assign slewing = (adj_cnt != '0);
  assign base    = slewing ? adj_period : period;
  assign fire    = (drift_rate != '0) && (dcnt == drift_rate - 1'b1);
  assign inc     = {1'b0, base} + (fire ? (PER_W+1)'(drift_amt) : '0);

  always_ff @(posedge clk) begin
    if (rst || rate_wr || drift_rate == '0) dcnt <= '0;
    else if (fire)                          dcnt <= '0;
    else                                    dcnt <= dcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          adj_cnt <= '0;
    else if (cnt_wr)  adj_cnt <= cnt_val;
    else if (slewing) adj_cnt <= adj_cnt - 1'b1;
  end

  // R6
  slew_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (adj_cnt != '0) && !cnt_wr |=> adj_cnt == $past(adj_cnt) - 1'b1);

  // R7
  drift_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (drift_rate == '0) ? (dcnt == '0) : (dcnt < drift_rate));
endmodule

// File: rtl/tod_regs.sv
module tod_regs #(
  parameter int SEC_W   = 48,
  parameter int NS_W    = 30,
  parameter int PER_W   = 20,
  parameter int CNT_W   = 20,
  parameter int DRIFT_W = 16,
  parameter int RATE_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [3:0]         bus_word,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [SEC_W-1:0]   time_sec,
  input  logic [NS_W-1:0]    time_ns,
  input  logic [CNT_W-1:0]   adj_cnt,
  output logic               load,
  output logic [SEC_W-1:0]   load_sec,
  output logic [NS_W-1:0]    load_ns,
  output logic [PER_W-1:0]   period,
  output logic [PER_W-1:0]   adj_period,
  output logic [DRIFT_W-1:0] drift_amt,
  output logic [RATE_W-1:0]  drift_rate,
  output logic               cnt_wr,
  output logic               rate_wr
);
  import tod_pkg::*;
  localparam int HI_W = SEC_W - 32;

  logic [HI_W-1:0]  stage_hi;
  logic [31:0]      stage_lo;
  logic [SEC_W-1:0] snap;

  assign load     = bus_wr && (bus_word == W_NS);
  assign load_sec = {stage_hi, stage_lo};
  assign load_ns  = bus_wdata[NS_W-1:0];
  assign cnt_wr   = bus_wr && (bus_word == W_ACNT);
  assign rate_wr  = bus_wr && (bus_word == W_DRATE);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_hi   <= '0;
      stage_lo   <= '0;
      period     <= '0;
      adj_period <= '0;
      drift_amt  <= '0;
      drift_rate <= '0;
    end else if (bus_wr) begin
      case (bus_word)
        W_SEC_HI: stage_hi   <= bus_wdata[HI_W-1:0];
        W_SEC_LO: stage_lo   <= bus_wdata;
        W_PER:    period     <= bus_wdata[PER_W-1:0];
        W_APER:   adj_period <= bus_wdata[PER_W-1:0];
        W_DAMT:   drift_amt  <= bus_wdata[DRIFT_W-1:0];
        W_DRATE:  drift_rate <= bus_wdata[RATE_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      snap      <= '0;
    end else if (bus_rd) begin
      case (bus_word)
        W_NS: begin
          bus_rdata <= 32'(time_ns);
          snap      <= time_sec;
        end
        W_SEC_HI: bus_rdata <= 32'(snap[SEC_W-1:32]);
        W_SEC_LO: bus_rdata <= snap[31:0];
        W_PER:    bus_rdata <= 32'(period);
        W_APER:   bus_rdata <= 32'(adj_period);
        W_ACNT:   bus_rdata <= 32'(adj_cnt);
        W_DAMT:   bus_rdata <= 32'(drift_amt);
        W_DRATE:  bus_rdata <= 32'(drift_rate);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  // R5
  ns_read_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd && (bus_word == W_NS) |=> bus_rdata == 32'($past(time_ns)));
endmodule

// File: rtl/tod_clock.sv
module tod_clock #(
  parameter int SEC_W   = 48,
  parameter int NS_W    = 30,
  parameter int FRAC_W  = 16,
  parameter int PER_W   = 20,
  parameter int CNT_W   = 20,
  parameter int DRIFT_W = 16,
  parameter int RATE_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [3:0]       bus_word,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [SEC_W-1:0] time_sec,
  output logic [NS_W-1:0]  time_ns
);
  localparam int INC_W = PER_W + 1;

  logic               load, cnt_wr, rate_wr;
  logic [SEC_W-1:0]   load_sec;
  logic [NS_W-1:0]    load_ns;
  logic [PER_W-1:0]   period, adj_period;
  logic [DRIFT_W-1:0] drift_amt;
  logic [RATE_W-1:0]  drift_rate;
  logic [CNT_W-1:0]   adj_cnt;
  logic [INC_W-1:0]   inc;

  tod_regs #(.SEC_W(SEC_W), .NS_W(NS_W), .PER_W(PER_W), .CNT_W(CNT_W),
             .DRIFT_W(DRIFT_W), .RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .time_sec(time_sec), .time_ns(time_ns), .adj_cnt(adj_cnt),
    .load(load), .load_sec(load_sec), .load_ns(load_ns),
    .period(period), .adj_period(adj_period), .drift_amt(drift_amt),
    .drift_rate(drift_rate), .cnt_wr(cnt_wr), .rate_wr(rate_wr));

  tod_slew #(.PER_W(PER_W), .CNT_W(CNT_W), .DRIFT_W(DRIFT_W),
             .RATE_W(RATE_W)) u_slew (
    .clk(clk), .rst(rst), .period(period), .adj_period(adj_period),
    .drift_amt(drift_amt), .drift_rate(drift_rate), .cnt_wr(cnt_wr),
    .cnt_val(bus_wdata[CNT_W-1:0]), .rate_wr(rate_wr), .inc(inc),
    .adj_cnt(adj_cnt));

  tod_time #(.SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W),
             .INC_W(INC_W)) u_time (
    .clk(clk), .rst(rst), .load(load), .load_sec(load_sec),
    .load_ns(load_ns), .inc(inc), .sec_o(time_sec), .ns_o(time_ns));
endmodule

// File: tb/test_tod_clock.sv
module test_tod_clock;
  localparam time CYC = 20ns;

  logic        clk = 0, rst = 1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [3:0]  bus_word = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [47:0] time_sec;
  logic [29:0] time_ns;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CYC/2) clk = ~clk;

  tod_clock i_tod_clock (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .time_sec(time_sec), .time_ns(time_ns));

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int off, logic [31:0] d);
    bus_wr = 1; bus_word = 4'(off >> 2); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(int off, output logic [31:0] d);
    bus_rd = 1; bus_word = 4'(off >> 2);
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_time(logic [47:0] s, logic [29:0] ns);
    wr(8'h00, 32'(s[47:32]));
    wr(8'h04, s[31:0]);
    wr(8'h08, 32'(ns));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a <= 8'h20; a += 4) begin
      rd(a, d);
      chk($sformatf("R1 reset read 0x%0h", a), d, 0);
    end
    idle(5);
    chk("R1 seconds stay zero", time_sec, 0);
    chk("R1 nanoseconds stay zero", time_ns, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d); chk("R8 period width", d, 32'hFFFFF);
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, d); chk("R8 slew period width", d, 32'hFFFFF);
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, d); chk("R8 drift amount width", d, 32'hFFFF);
    wr(8'h20, 32'hFFFF_1234); rd(8'h20, d); chk("R8 drift interval width", d, 32'h1234);
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, d); chk("R8 reserved word", d, 0);
    wr(8'h20, 0);
    wr(8'h10, 0);
  endtask

  task automatic t_stage;
    wr(8'h10, 0);
    set_time(48'h0, 30'd5);
    wr(8'h00, 32'h1234);
    wr(8'h04, 32'h89AB_CDEF);
    chk("R4 staged seconds do not load", time_sec, 0);
    chk("R4 staged write keeps ns", time_ns, 5);
    wr(8'h08, 32'd77);
    chk("R4 seconds loaded by ns write", time_sec, 48'h1234_89AB_CDEF);
    chk("R4 ns loaded", time_ns, 77);
  endtask

  task automatic t_advance;
    wr(8'h10, 32'h18000);
    wr(8'h08, 32'd500);
    idle(10);
    chk("R2 1.5ns x10", time_ns, 515);
    idle(1);
    chk("R2 fraction kept", time_ns, 516);
    wr(8'h08, 32'd200);
    idle(1);
    chk("R4 fraction cleared on ns write", time_ns, 201);
  endtask

  task automatic t_roll;
    wr(8'h10, 32'h80000);
    set_time(48'd5, 30'd999_999_992);
    idle(1);
    chk("R3 ns wrap", time_ns, 0);
    chk("R3 seconds carry", time_sec, 6);
    set_time(48'h0000_FFFF_FFFF, 30'd999_999_992);
    idle(1);
    chk("R3 48-bit carry", time_sec, 48'h1_0000_0000);
  endtask

  task automatic t_snap;
    logic [31:0] d;
    wr(8'h10, 32'h80000);
    set_time(48'd7, 30'd999_999_990);
    rd(8'h08, d);
    chk("R5 ns read value", d, 999_999_990);
    idle(1);
    chk("R5 live seconds rolled", time_sec, 8);
    rd(8'h04, d);
    chk("R5 seconds-low from snapshot", d, 7);
    set_time(48'h2_0000_0001, 30'd10);
    rd(8'h08, d);
    rd(8'h00, d);
    chk("R5 seconds-high upper half zero", d, 2);
  endtask

  task automatic t_slew;
    logic [31:0] d;
    wr(8'h10, 32'h80000);
    set_time(48'd1, 30'd1000);
    wr(8'h14, 32'hA0000);
    chk("R6 pre-slew ns", time_ns, 1008);
    wr(8'h18, 32'd4);
    idle(9);
    chk("R6 slew 4 cycles of 10ns", time_ns, 1096);
    rd(8'h18, d);
    chk("R6 count done reads zero", d, 0);
    wr(8'h14, 32'h60000);
    wr(8'h18, 32'd3);
    rd(8'h18, d);
    chk("R6 count busy", d, 3);
    idle(3);
    rd(8'h18, d);
    chk("R6 count reaches zero", d, 0);
  endtask

  task automatic t_drift;
    wr(8'h10, 0);
    wr(8'h1C, 32'h8000);
    wr(8'h20, 32'd4);
    wr(8'h08, 0);
    idle(14);
    chk("R7 three drift steps", time_ns, 1);
    idle(2);
    chk("R7 four drift steps", time_ns, 2);
    wr(8'h20, 0);
    wr(8'h08, 0);
    idle(20);
    chk("R7 interval zero disables", time_ns, 0);
    wr(8'h20, 32'd1);
    wr(8'h08, 0);
    idle(4);
    chk("R7 interval one every edge", time_ns, 2);
  endtask

  initial begin
    idle(3);
    rst = 0;
    idle(1);
    t_reset();
    t_regs();
    t_stage();
    t_advance();
    t_roll();
    t_snap();
    t_slew();
    t_drift();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CYC * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule